// File: doc/BRIEF.md
# Programmable Square-Wave and Pulse Timer

This block is a 14-bit down-counting timer. It advances on a timer-input qualifier, `tick_in`, which is sampled once per system clock. Software writes a 16-bit count-length word one byte at a time. Fourteen bits of that word hold the period length `n`, in tick periods. The two remaining bits choose the output shape:

- a square wave that runs once or repeats;
- a single low pulse at terminal count, or a repeating one.

The counter moves down by two on each tick and passes through each half of the period in turn. This gives an odd period a high half one tick longer than its low half.

A two-bit command with a strobe controls the timer. The commands are immediate stop, stop at the next terminal count, and start. A start issued while the timer is already running waits until the current period reaches terminal count. A sticky flag records terminal count until it is cleared. Reading the two bytes returns the live counter and the active output shape. It does not return the number of ticks seen so far.

Top module: `tmr_sqwave`

## Requirements
- R1: A write with `wr_hi`=0 loads length bits 7:0 from `wr_data`. A write with `wr_hi`=1 loads length bits 13:8 from `wr_data[5:0]` and the shape code from `wr_data[7:6]`. Shape bit 1 selects pulse (1) or square (0). Shape bit 0 selects repeat (1) or single (0).
- R2: Shape 00 with length n gives one square period after START. The output is high for ceil(n/2) tick periods, counting from START, then low for floor(n/2). It then stays high with the timer stopped.
- R3: Shape 01 repeats the R2 waveform without a gap, reloading the same length at every terminal count.
- R4: Shape 10 keeps the output high for n ticks, then drives it low for exactly one tick period after the n-th tick, then stops with the output high.
- R5: Shape 11 gives the R4 one-period low pulse after every n-th tick and keeps counting.
- R6: Command 01 (STOP) stops the timer at once. The output is high from the next cycle and does not change on later ticks. Command 00 has no effect.
- R7: Command 10 stops the timer at the next terminal count instead of reloading it.
- R8: Command 11 (START) loads the length and shape and starts at once when the timer is idle. When the timer is running, the load waits until the next terminal count, and the new length and shape take effect from there.
- R9: Writing the length register while the timer runs changes neither the waveform nor the reload value until a START is issued.
- R10: With `rd_hi`=0, `rd_data` is counter bits 7:0. With `rd_hi`=1, it is {active shape, counter bits 13:8}. Right after START the counter equals n, and each tick inside a half period lowers it by two.
- R11: `tc_flag` rises on the cycle after the terminal-count tick. It stays set until `tc_clr` is asserted without a new terminal count.
- R12: Synchronous active-low reset stops the timer, drives the output high and clears `tc_flag`. Counting resumes only after a new START.
- R13: `tmr_out` changes only in the cycle after a tick or a command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Byte write strobe for the length register |
| wr_hi | input | 1 | Selects the upper byte for writes |
| wr_data | input | 8 | Write data |
| rd_hi | input | 1 | Selects the upper byte for reads |
| rd_data | output | 8 | Counter or shape read data |
| cmd_valid | input | 1 | Command strobe |
| cmd | input | 2 | Command code: 00 none, 01 stop, 10 stop at TC, 11 start |
| tick_in | input | 1 | One-cycle timer-input qualifier |
| tmr_out | output | 1 | Square-wave or pulse output |
| tc_flag | output | 1 | Sticky terminal-count flag |
| tc_clr | input | 1 | Clears `tc_flag` |

## Verification
Ticks, commands, writes and clears all act at the clock edge that samples them. The output, the flag and the counter read-back are therefore settled one cycle after that stimulus, and `rd_data` is a direct view of the counter register. The bench drives every input at the falling edge and holds it for one cycle. It samples at the next falling edge, which is half a cycle after the edge that used the stimulus. Each tick-period sample is then compared with a waveform computed from the length, the shape code and the tick index.

// File: rtl/tmr_pkg.sv
// Package: shared command encoding for the square-wave timer.
// Assumes a two-bit command bus driven with a one-cycle strobe.
package tmr_pkg;
    typedef enum logic [1:0] {
        CMD_NOP     = 2'b00,
        CMD_STOP    = 2'b01,
        CMD_STOP_TC = 2'b10,
        CMD_START   = 2'b11
    } tmr_cmd_e;
endpackage

// File: rtl/tmr_len_reg.sv
// Module: count-length holding register, written one byte at a time.
// Assumes LEN_W = CNT_W + 2 = 16, so the upper byte holds shape and count MSBs.
// The register has no reset, because the length is undefined after reset.
module tmr_len_reg #(
    parameter int CNT_W = 14,
    localparam int LEN_W = CNT_W + 2
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic             wr_hi,
    input  logic [7:0]       wr_data,
    output logic [LEN_W-1:0] len_o
);
    logic [LEN_W-1:0] len_q;

    // Capture the addressed byte on a write strobe.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            if (wr_hi) len_q[LEN_W-1:8] <= wr_data[LEN_W-9:0];
            else       len_q[7:0]       <= wr_data;
        end
    end

    assign len_o = len_q;
endmodule

// File: rtl/tmr_seq.sv
// Module: counter sequencer. Counts down by two through a high half and then a low half.
// It also handles commands, deferred start, stop-at-TC and repeat reload.
// Assumes tick_i is high for one clock per timer-input pulse and lengths are at least 2.
module tmr_seq
    import tmr_pkg::*;
#(
    parameter int CNT_W = 14,
    localparam int LEN_W = CNT_W + 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             cmd_valid_i,
    input  logic [1:0]       cmd_i,
    input  logic [LEN_W-1:0] len_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic [1:0]       mode_o,
    output logic             run_o,
    output logic             low_o,
    output logic             tc_o,
    output logic             stop_o
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] len_act_q;
    logic [1:0]       mode_q;
    logic             run_q, low_q, start_pend_q, stop_pend_q;
    tmr_cmd_e         cmd_e;
    logic             half_end;

    // Decode the command strobe and detect the end of a half period.
    always_comb begin
        cmd_e    = tmr_cmd_e'(cmd_i);
        half_end = (cnt_q <= CNT_W'(2));
        stop_o   = cmd_valid_i && (cmd_e == CMD_STOP);
        tc_o     = run_q && tick_i && low_q && half_end && !stop_o;
    end

    // Advance the counter, sequence the halves and apply commands.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q        <= 1'b0;
            low_q        <= 1'b0;
            start_pend_q <= 1'b0;
            stop_pend_q  <= 1'b0;
        end else if (stop_o) begin
            run_q        <= 1'b0;
            start_pend_q <= 1'b0;
            stop_pend_q  <= 1'b0;
        end else begin
            if (run_q && tick_i) begin
                if (!half_end) begin
                    cnt_q <= cnt_q - CNT_W'(2);
                end else if (!low_q) begin
                    low_q <= 1'b1;
                    cnt_q <= {len_act_q[CNT_W-1:1], 1'b0};
                end else if (start_pend_q) begin
                    cnt_q        <= len_i[CNT_W-1:0];
                    len_act_q    <= len_i[CNT_W-1:0];
                    mode_q       <= len_i[LEN_W-1:CNT_W];
                    low_q        <= 1'b0;
                    start_pend_q <= 1'b0;
                end else if (stop_pend_q || !mode_q[0]) begin
                    run_q       <= 1'b0;
                    stop_pend_q <= 1'b0;
                end else begin
                    low_q <= 1'b0;
                    cnt_q <= len_act_q;
                end
            end
            if (cmd_valid_i && cmd_e == CMD_START) begin
                if (!run_q) begin
                    cnt_q        <= len_i[CNT_W-1:0];
                    len_act_q    <= len_i[CNT_W-1:0];
                    mode_q       <= len_i[LEN_W-1:CNT_W];
                    low_q        <= 1'b0;
                    run_q        <= 1'b1;
                    start_pend_q <= 1'b0;
                    stop_pend_q  <= 1'b0;
                end else begin
                    start_pend_q <= 1'b1;
                    stop_pend_q  <= 1'b0;
                end
            end
            if (cmd_valid_i && cmd_e == CMD_STOP_TC && run_q) begin
                stop_pend_q  <= 1'b1;
                start_pend_q <= 1'b0;
            end
        end
    end

    assign cnt_o  = cnt_q;
    assign mode_o = mode_q;
    assign run_o  = run_q;
    assign low_o  = low_q;
endmodule

// File: rtl/tmr_wave.sv
// Module: output shaper and terminal-count flag.
// Square shapes follow the half-period phase. Pulse shapes drive the output low
// for the one tick period that follows terminal count.
// Assumes tc_i is high only in a cycle where a tick is also present.
module tmr_wave (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic stop_i,
    input  logic tc_i,
    input  logic pulse_mode_i,
    input  logic run_i,
    input  logic low_i,
    input  logic clr_i,
    output logic out_o,
    output logic flag_o
);
    logic pulse_q, flag_q;

    // Hold the pulse low for one tick period after terminal count.
    always_ff @(posedge clk) begin
        if (!rst_n)                    pulse_q <= 1'b0;
        else if (stop_i)               pulse_q <= 1'b0;
        else if (tc_i && pulse_mode_i) pulse_q <= 1'b1;
        else if (tick_i)               pulse_q <= 1'b0;
    end

    // Sticky terminal-count flag. A new terminal count wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)     flag_q <= 1'b0;
        else if (tc_i)  flag_q <= 1'b1;
        else if (clr_i) flag_q <= 1'b0;
    end

    assign out_o  = !pulse_q && !(run_i && !pulse_mode_i && low_i);
    assign flag_o = flag_q;
endmodule

// File: rtl/tmr_sqwave.sv
// Module: top of the programmable square-wave and pulse timer.
// Ties together the length register, the sequencer and the output shaper.
// Assumes CNT_W = 14, so that the upper byte holds two shape bits and six count bits.
module tmr_sqwave #(
    parameter int CNT_W = 14
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic       wr_hi,
    input  logic [7:0] wr_data,
    input  logic       rd_hi,
    output logic [7:0] rd_data,
    input  logic       cmd_valid,
    input  logic [1:0] cmd,
    input  logic       tick_in,
    output logic       tmr_out,
    output logic       tc_flag,
    input  logic       tc_clr
);
    localparam int LEN_W = CNT_W + 2;
    localparam int HI_W  = CNT_W - 8;

    logic [LEN_W-1:0] len;
    logic [CNT_W-1:0] cnt;
    logic [1:0]       mode;
    logic             run, low, tc, stop_now;

    tmr_len_reg #(.CNT_W(CNT_W)) u_len (
        .clk(clk), .wr_en(wr_en), .wr_hi(wr_hi), .wr_data(wr_data), .len_o(len)
    );

    tmr_seq #(.CNT_W(CNT_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_in), .cmd_valid_i(cmd_valid),
        .cmd_i(cmd), .len_i(len), .cnt_o(cnt), .mode_o(mode), .run_o(run),
        .low_o(low), .tc_o(tc), .stop_o(stop_now)
    );

    tmr_wave u_wave (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_in), .stop_i(stop_now), .tc_i(tc),
        .pulse_mode_i(mode[1]), .run_i(run), .low_i(low), .clr_i(tc_clr),
        .out_o(tmr_out), .flag_o(tc_flag)
    );

    // Read-back mux: live counter with the active shape in the upper byte.
    always_comb begin
        if (rd_hi) rd_data = {mode, cnt[CNT_W-1:CNT_W-HI_W]};
        else       rd_data = cnt[7:0];
    end
endmodule

// File: rtl/tmr_sqwave_chk.sv
// Module: assertion checker for the timer, bound to the top module.
// It observes ports only.
module tmr_sqwave_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tick_in,
    input logic       cmd_valid,
    input logic [1:0] cmd,
    input logic       tc_clr,
    input logic       tmr_out,
    input logic       tc_flag
);
    // R13: with no tick and no command, the output holds its value.
    assert_out_quiet_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_in && !cmd_valid) |=> $stable(tmr_out));

    // R6: an immediate stop leaves the output high on the next cycle.
    assert_stop_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd == 2'b01) |=> tmr_out);

    // R11: the flag stays set until it is cleared.
    assert_flag_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (tc_flag && !tc_clr) |=> tc_flag);

    // R11: a clear with no tick empties the flag.
    assert_flag_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (tc_clr && !tick_in) |=> !tc_flag);

    // R11: the flag rises only after a tick.
    assert_flag_on_tick_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tc_flag) |-> $past(tick_in));
endmodule

bind tmr_sqwave tmr_sqwave_chk u_chk (
    .clk(clk), .rst_n(rst_n), .tick_in(tick_in), .cmd_valid(cmd_valid), .cmd(cmd),
    .tc_clr(tc_clr), .tmr_out(tmr_out), .tc_flag(tc_flag)
);

// File: tb/tmr_sqwave_bench.sv
module tmr_sqwave_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0, wr_hi = 1'b0, rd_hi = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       cmd_valid = 1'b0;
    logic [1:0] cmd = 2'b00;
    logic       tick_in = 1'b0, tc_clr = 1'b0;
    logic       tmr_out, tc_flag;
    int         n_run = 0, n_fail = 0;
    bit         done = 1'b0;

    always #2 clk = ~clk;

    tmr_sqwave u_tmr_sqwave (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_hi(wr_hi), .wr_data(wr_data),
        .rd_hi(rd_hi), .rd_data(rd_data), .cmd_valid(cmd_valid), .cmd(cmd),
        .tick_in(tick_in), .tmr_out(tmr_out), .tc_flag(tc_flag), .tc_clr(tc_clr)
    );

    // Stimulus table: {shape[1:0], length[13:0]}.
    localparam logic [15:0] VEC [10] = '{
        {2'b00, 14'd4}, {2'b00, 14'd9}, {2'b01, 14'd5}, {2'b01, 14'd2},
        {2'b01, 14'd6}, {2'b10, 14'd3}, {2'b10, 14'd6}, {2'b11, 14'd7},
        {2'b11, 14'd2}, {2'b00, 14'd3}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr_byte(input bit hi, input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; wr_hi = hi; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic wr_len(input logic [1:0] m, input int n);
        wr_byte(1'b0, n[7:0]);
        wr_byte(1'b1, {m, n[13:8]});
    endtask

    task automatic issue(input logic [1:0] c);
        @(negedge clk); cmd_valid = 1'b1; cmd = c;
        @(negedge clk); cmd_valid = 1'b0;
    endtask

    task automatic tick();
        @(negedge clk); tick_in = 1'b1;
        @(negedge clk); tick_in = 1'b0;
    endtask

    task automatic clear_flag();
        @(negedge clk); tc_clr = 1'b1;
        @(negedge clk); tc_clr = 1'b0;
    endtask

    task automatic read_hi(input bit hi);
        @(negedge clk); rd_hi = hi;
        #1;
    endtask

    // Expected output after j ticks following START.
    function automatic bit exp_out(input logic [1:0] m, input int n, input int j);
        int h = (n + 1) / 2;
        case (m)
            2'b00:   return (j < h) || (j >= n);
            2'b01:   return (j % n) < h;
            2'b10:   return j != n;
            default: return !(j > 0 && (j % n) == 0);
        endcase
    endfunction

    initial begin
        #(4 * 150000);
        chk(1'b0, "watchdog", 0, 1);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R12: state after reset.
        chk(tmr_out === 1'b1, "R12 out after reset", tmr_out, 1);
        chk(tc_flag === 1'b0, "R12 flag after reset", tc_flag, 0);
        @(negedge clk); rst_n = 1'b1;

        // Table walk: R2, R3, R4, R5 waveforms and the R11 flag.
        for (int v = 0; v < 10; v++) begin
            automatic logic [1:0] m = VEC[v][15:14];
            automatic int n = int'(VEC[v][13:0]);
            automatic string rq = (m == 2'b00) ? "R2" : (m == 2'b01) ? "R3" :
                                  (m == 2'b10) ? "R4" : "R5";
            issue(2'b01);
            clear_flag();
            wr_len(m, n);
            issue(2'b11);
            for (int j = 0; j <= 2 * n + 1; j++) begin
                if (j > 0) tick();
                chk(tmr_out === exp_out(m, n, j), rq, tmr_out, exp_out(m, n, j));
                if (j == n - 1) chk(tc_flag === 1'b0, "R11 flag before TC", tc_flag, 0);
                if (j == n)     chk(tc_flag === 1'b1, "R11 flag at TC", tc_flag, 1);
            end
        end

        // R11: clear.
        clear_flag();
        chk(tc_flag === 1'b0, "R11 clear", tc_flag, 0);

        // R1, R10: byte layout and read-back.
        issue(2'b01);
        wr_len(2'b01, 14'h1235);
        issue(2'b11);
        read_hi(1'b0); chk(rd_data === 8'h35, "R10 read low", rd_data, 8'h35);
        read_hi(1'b1); chk(rd_data === 8'h52, "R1 read high", rd_data, 8'h52);
        tick();
        read_hi(1'b0); chk(rd_data === 8'h33, "R10 after tick", rd_data, 8'h33);

        // R9: a write while running does not change the waveform.
        issue(2'b01);
        wr_len(2'b01, 4);
        issue(2'b11);
        wr_len(2'b01, 6);
        tick(); tick();
        chk(tmr_out === 1'b0, "R9 low at j2", tmr_out, 0);
        repeat (4) tick();
        chk(tmr_out === 1'b0, "R9 reload old length", tmr_out, 0);

        // R8: a START issued while running is deferred to terminal count.
        issue(2'b01);
        wr_len(2'b01, 4);
        issue(2'b11);
        wr_len(2'b11, 6);
        tick();
        issue(2'b11);
        tick();
        chk(tmr_out === 1'b0, "R8 old waveform kept", tmr_out, 0);
        tick(); tick();
        chk(tmr_out === 1'b1, "R8 new run at TC", tmr_out, 1);
        read_hi(1'b1); chk(rd_data === 8'hC0, "R8 new shape loaded", rd_data, 8'hC0);
        read_hi(1'b0); chk(rd_data === 8'h06, "R8 new length loaded", rd_data, 6);
        repeat (5) tick();
        chk(tmr_out === 1'b1, "R8 before new pulse", tmr_out, 1);
        tick();
        chk(tmr_out === 1'b0, "R8 new pulse", tmr_out, 0);

        // R6: immediate stop, and command 00 has no effect.
        issue(2'b01);
        clear_flag();
        wr_len(2'b01, 4);
        issue(2'b11);
        tick(); tick();
        issue(2'b00);
        chk(tmr_out === 1'b0, "R6 nop no effect", tmr_out, 0);
        issue(2'b01);
        chk(tmr_out === 1'b1, "R6 stop high", tmr_out, 1);
        repeat (5) tick();
        chk(tmr_out === 1'b1, "R6 stays stopped", tmr_out, 1);
        chk(tc_flag === 1'b0, "R6 no TC after stop", tc_flag, 0);

        // R7: stop at the next terminal count.
        issue(2'b11);
        tick();
        issue(2'b10);
        repeat (3) tick();
        chk(tc_flag === 1'b1, "R7 TC reached", tc_flag, 1);
        tick(); tick();
        chk(tmr_out === 1'b1, "R7 stopped after TC", tmr_out, 1);

        // R12: reset in the middle of a run.
        clear_flag();
        issue(2'b11);
        tick(); tick();
        chk(tmr_out === 1'b0, "R12 running low", tmr_out, 0);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); @(negedge clk); rst_n = 1'b1;
        chk(tmr_out === 1'b1, "R12 out after mid reset", tmr_out, 1);
        repeat (4) tick();
        chk(tmr_out === 1'b1, "R12 stays stopped", tmr_out, 1);
        chk(tc_flag === 1'b0, "R12 no flag", tc_flag, 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule